// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Outputs

This block is a purely combinational shifter for a 32-bit integer datapath. It performs logical left, logical right and arithmetic right shifts, and it produces the bit that was last shifted out as a new carry flag. It also provides an extend flag that is a copy of that carry. The shift distance is taken modulo 64. This gives four distance classes, each with its own result and carry rule:

- **Zero distance.** The operand passes through unchanged, and the caller's previous carry is kept.
- **Partial distance (1 to 31).** This is an ordinary shift. The carry is the last bit that left the word.
- **Full distance (exactly 32).** The result is all zeros, or all sign bits for an arithmetic shift. The carry is still the edge bit of the operand.
- **Over distance (33 to 63).** The result is zero or sign-filled. The carry is zero, or the sign bit for an arithmetic shift.

The condition-code logic that owns the flag register feeds its current carry into `carry_in` and stores `carry_out` and `extend_out` itself. A fourth code on the kind selector is a hold operation: the operand and the carry pass through unchanged.

Internally, a single right-shifting logarithmic core serves every kind of shift:

- A left shift reverses the word before the core and again after it.
- The core carries one extra guard bit below the word, which captures the last bit shifted out.
- A distance classifier sorts the count into its class (none, partial, full, over).
- A select stage picks result and carry according to the class and the shift kind.

Top module: `bshift_unit`

## Requirements
- R1: Only the low 6 bits of `amount_in` (count modulo 64) affect the outputs. Amounts that are equal modulo 64 give identical results.
- R2: A count of 0 gives `data_out` = `data_in` and `carry_out` = `carry_in`, for every shift kind.
- R3: With `kind_sel` = 2'b00 (logical left) and a count n from 1 to 31, `data_out` = `data_in` << n and `carry_out` = `data_in[32-n]`.
- R4: A logical left shift by exactly 32 gives `data_out` = 0 and `carry_out` = `data_in[0]`. A logical left shift by 33 to 63 gives `data_out` = 0 and `carry_out` = 0.
- R5: With `kind_sel` = 2'b01 (logical right):
  - For n from 1 to 31, `data_out` = `data_in` >> n and `carry_out` = `data_in[n-1]`.
  - For n = 32, `data_out` = 0 and `carry_out` = `data_in[31]`.
  - For n from 33 to 63, `data_out` = 0 and `carry_out` = 0.
- R6: With `kind_sel` = 2'b10 (arithmetic right):
  - For n from 1 to 31, the vacated upper bits take `data_in[31]` and `carry_out` = `data_in[n-1]`.
  - For n from 32 to 63, every bit of `data_out` equals `data_in[31]`, and so does `carry_out`.
- R7: `extend_out` always equals `carry_out`.
- R8: With `kind_sel` = 2'b11 (hold), `data_out` = `data_in` and `carry_out` = `carry_in` for any count.
- R9: The block has no state. The outputs depend only on the present inputs, with no latency, and all-zero inputs give all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| kind_sel | input | 2 | Shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 hold |
| amount_in | input | AMT_IN_W (8) | Shift distance; taken modulo 2*DATA_W |
| data_in | input | DATA_W (32) | Operand |
| carry_in | input | 1 | Previous carry flag, kept on zero distance or hold |
| data_out | output | DATA_W (32) | Shifted result |
| carry_out | output | 1 | New carry flag |
| extend_out | output | 1 | New extend flag, equal to the new carry |

## Verification
The bound checker uses immediate assertions that are evaluated whenever an input changes. They take for granted that every input is a defined 0 or 1: the checker skips its properties while any input carries X or Z, so values before the first drive are never judged. The bench drives every input to a defined value during reset and only changes the inputs on falling clock edges. The scoreboard reads the outputs on the rising edge that follows, half a period after the last input change, so the combinational result has settled.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    // Kind of shift requested by the caller (field encoding fixed by R3, R5, R6, R8)
    typedef enum logic [1:0] {
        SH_LSL  = 2'b00,
        SH_LSR  = 2'b01,
        SH_ASR  = 2'b10,
        SH_HOLD = 2'b11
    } shift_kind_e;

    // Class of the reduced shift distance
    typedef enum logic [1:0] {
        SPAN_NONE = 2'd0,   // distance 0
        SPAN_PART = 2'd1,   // 1 .. width-1
        SPAN_FULL = 2'd2,   // exactly width
        SPAN_OVER = 2'd3    // width+1 .. 2*width-1
    } span_e;

endpackage

// File: rtl/bshift_span_classify.sv
module bshift_span_classify
    import bshift_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_IN_W = 8
) (
    input  logic [AMT_IN_W-1:0]            amount_in,
    output span_e                          span,
    output logic [$clog2(DATA_W)-1:0]      part_amt
);
    localparam int STAGE_W = $clog2(DATA_W);
    localparam int CNT_W   = STAGE_W + 1;
    localparam logic [AMT_IN_W-1:0] AMT_MASK = AMT_IN_W'((2 * DATA_W) - 1);
    localparam logic [CNT_W-1:0]    FULL_CNT = CNT_W'(DATA_W);

    logic [CNT_W-1:0] cnt;

    // Distance reduced modulo 2*DATA_W (R1)
    assign cnt      = CNT_W'(amount_in & AMT_MASK);
    assign part_amt = cnt[STAGE_W-1:0];

    always_comb begin
        if (cnt == '0) begin
            span = SPAN_NONE;
        end else if (cnt < FULL_CNT) begin
            span = SPAN_PART;
        end else if (cnt == FULL_CNT) begin
            span = SPAN_FULL;
        end else begin
            span = SPAN_OVER;
        end
    end

endmodule

// File: rtl/bshift_reverse.sv
module bshift_reverse #(
    parameter int DATA_W = 32
) (
    input  logic              enable,
    input  logic [DATA_W-1:0] vin,
    output logic [DATA_W-1:0] vout
);
    logic [DATA_W-1:0] flipped;

    for (genvar b = 0; b < DATA_W; b++) begin : g_flip
        assign flipped[b] = vin[DATA_W-1-b];
    end

    assign vout = enable ? flipped : vin;

endmodule

// File: rtl/bshift_right_core.sv
module bshift_right_core #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]          vin,
    input  logic                       fill,
    input  logic [$clog2(DATA_W)-1:0]  amt,
    output logic [DATA_W-1:0]          vout,
    output logic                       last_out
);
    localparam int STAGE_W = $clog2(DATA_W);
    localparam int EXT_W   = DATA_W + 1;

    // One guard bit below the word catches the last bit shifted out
    logic [EXT_W-1:0] stage [0:STAGE_W];

    assign stage[0] = {vin, 1'b0};

    for (genvar s = 0; s < STAGE_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt[s] ? {{STEP{fill}}, stage[s][EXT_W-1:STEP]}
                                   : stage[s];
    end

    assign vout     = stage[STAGE_W][EXT_W-1:1];
    assign last_out = stage[STAGE_W][0];

endmodule

// File: rtl/bshift_carry_select.sv
module bshift_carry_select
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shift_kind_e       kind,
    input  span_e             span,
    input  logic [DATA_W-1:0] data_in,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] part_result,
    input  logic              part_carry,
    output logic [DATA_W-1:0] data_out,
    output logic              carry_out
);
    logic sign_bit;
    logic low_bit;

    assign sign_bit = data_in[DATA_W-1];
    assign low_bit  = data_in[0];

    always_comb begin
        data_out  = data_in;
        carry_out = carry_in;
        if (kind != SH_HOLD) begin
            unique case (span)
                SPAN_NONE: begin
                    data_out  = data_in;
                    carry_out = carry_in;
                end
                SPAN_PART: begin
                    data_out  = part_result;
                    carry_out = part_carry;
                end
                SPAN_FULL: begin
                    unique case (kind)
                        SH_LSL: begin
                            data_out  = '0;
                            carry_out = low_bit;
                        end
                        SH_LSR: begin
                            data_out  = '0;
                            carry_out = sign_bit;
                        end
                        default: begin
                            data_out  = {DATA_W{sign_bit}};
                            carry_out = sign_bit;
                        end
                    endcase
                end
                SPAN_OVER: begin
                    if (kind == SH_ASR) begin
                        data_out  = {DATA_W{sign_bit}};
                        carry_out = sign_bit;
                    end else begin
                        data_out  = '0;
                        carry_out = 1'b0;
                    end
                end
                default: begin
                    data_out  = data_in;
                    carry_out = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
    import bshift_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int AMT_IN_W = 8
) (
    input  logic [1:0]          kind_sel,
    input  logic [AMT_IN_W-1:0] amount_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic                carry_in,
    output logic [DATA_W-1:0]   data_out,
    output logic                carry_out,
    output logic                extend_out
);
    localparam int STAGE_W = $clog2(DATA_W);

    shift_kind_e        kind;
    span_e              span;
    logic [STAGE_W-1:0] part_amt;
    logic               is_left;
    logic               fill_bit;
    logic [DATA_W-1:0]  core_in;
    logic [DATA_W-1:0]  core_out;
    logic [DATA_W-1:0]  part_result;
    logic               part_carry;
    logic               new_carry;

    assign kind     = shift_kind_e'(kind_sel);
    assign is_left  = (kind == SH_LSL);
    assign fill_bit = (kind == SH_ASR) ? data_in[DATA_W-1] : 1'b0;

    bshift_span_classify #(
        .DATA_W   (DATA_W),
        .AMT_IN_W (AMT_IN_W)
    ) u_span (
        .amount_in (amount_in),
        .span      (span),
        .part_amt  (part_amt)
    );

    // Left shifts run through the right-shift core between two reversals
    bshift_reverse #(.DATA_W(DATA_W)) u_rev_pre (
        .enable (is_left),
        .vin    (data_in),
        .vout   (core_in)
    );

    bshift_right_core #(.DATA_W(DATA_W)) u_core (
        .vin      (core_in),
        .fill     (fill_bit),
        .amt      (part_amt),
        .vout     (core_out),
        .last_out (part_carry)
    );

    bshift_reverse #(.DATA_W(DATA_W)) u_rev_post (
        .enable (is_left),
        .vin    (core_out),
        .vout   (part_result)
    );

    bshift_carry_select #(.DATA_W(DATA_W)) u_sel (
        .kind        (kind),
        .span        (span),
        .data_in     (data_in),
        .carry_in    (carry_in),
        .part_result (part_result),
        .part_carry  (part_carry),
        .data_out    (data_out),
        .carry_out   (new_carry)
    );

    assign carry_out  = new_carry;
    assign extend_out = new_carry;

endmodule

// File: rtl/bshift_unit_chk.sv
module bshift_unit_chk #(
    parameter int DATA_W   = 32,
    parameter int AMT_IN_W = 8
) (
    input logic [1:0]          kind_sel,
    input logic [AMT_IN_W-1:0] amount_in,
    input logic [DATA_W-1:0]   data_in,
    input logic                carry_in,
    input logic [DATA_W-1:0]   data_out,
    input logic                carry_out,
    input logic                extend_out
);
    int  n;
    logic known;
    logic sgn;

    always_comb begin
        known = !$isunknown({kind_sel, amount_in, data_in, carry_in,
                             data_out, carry_out, extend_out});
        n     = int'(amount_in) % (2 * DATA_W);
        sgn   = data_in[DATA_W-1];
        if (known) begin
            a_r7_extend_follows_carry:
                assert (extend_out == carry_out)
                else $error("R7 extend differs from carry");
            if (n == 0) begin
                a_r2_zero_count_passthrough:
                    assert (data_out == data_in && carry_out == carry_in)
                    else $error("R2 zero count altered operand or carry");
            end
            if (kind_sel == 2'b11) begin
                a_r8_hold_passthrough:
                    assert (data_out == data_in && carry_out == carry_in)
                    else $error("R8 hold altered operand or carry");
            end
            if (kind_sel == 2'b00 && n > DATA_W) begin
                a_r4_left_over_clears:
                    assert (data_out == '0 && !carry_out)
                    else $error("R4 long left shift not cleared");
            end
            if (kind_sel == 2'b01 && n >= DATA_W) begin
                a_r5_right_long_zero:
                    assert (data_out == '0)
                    else $error("R5 long logical right not zero");
            end
            if (kind_sel == 2'b10 && n >= DATA_W) begin
                a_r6_asr_long_sign:
                    assert (data_out == {DATA_W{sgn}} && carry_out == sgn)
                    else $error("R6 long arithmetic right not sign filled");
            end
        end
    end

endmodule

bind bshift_unit bshift_unit_chk #(
    .DATA_W   (DATA_W),
    .AMT_IN_W (AMT_IN_W)
) u_chk (
    .kind_sel   (kind_sel),
    .amount_in  (amount_in),
    .data_in    (data_in),
    .carry_in   (carry_in),
    .data_out   (data_out),
    .carry_out  (carry_out),
    .extend_out (extend_out)
);

// File: tb/bshift_unit_test.sv
module bshift_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  kind_sel = 2'b00;
    logic [7:0]  amount_in = 8'd0;
    logic [31:0] data_in = 32'd0;
    logic        carry_in = 1'b0;
    logic [31:0] data_out;
    logic        carry_out;
    logic        extend_out;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] q_data [$];
    logic        q_carry [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    bshift_unit #(.DATA_W(32), .AMT_IN_W(8)) uut (
        .kind_sel   (kind_sel),
        .amount_in  (amount_in),
        .data_in    (data_in),
        .carry_in   (carry_in),
        .data_out   (data_out),
        .carry_out  (carry_out),
        .extend_out (extend_out)
    );

    // Reference built from the requirement text, bit by bit
    task automatic ref_model(input logic [1:0] m, input logic [7:0] a,
                             input logic [31:0] v, input logic cin,
                             output logic [31:0] r, output logic c);
        int k;
        k = int'(a) % 64;
        r = v;
        c = cin;
        if (m != 2'b11 && k != 0) begin
            for (int i = 0; i < 32; i++) begin
                if (m == 2'b00)
                    r[i] = (i - k >= 0) ? v[i-k] : 1'b0;
                else if (m == 2'b01)
                    r[i] = (i + k < 32) ? v[i+k] : 1'b0;
                else
                    r[i] = (i + k < 32) ? v[i+k] : v[31];
            end
            if (m == 2'b00)
                c = (k <= 32) ? v[32-k] : 1'b0;
            else if (m == 2'b01)
                c = (k <= 32) ? v[k-1] : 1'b0;
            else
                c = (k <= 32) ? v[k-1] : v[31];
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [7:0] a,
                         input logic [31:0] v, input logic cin, input string tag);
        logic [31:0] er;
        logic        ec;
        @(negedge clk);
        kind_sel  = m;
        amount_in = a;
        data_in   = v;
        carry_in  = cin;
        ref_model(m, a, v, cin, er, ec);
        q_data.push_back(er);
        q_carry.push_back(ec);
        q_tag.push_back(tag);
    endtask

    // Monitor: results settle half a period after each falling-edge drive
    always @(posedge clk) begin
        if (q_data.size() > 0) begin
            logic [31:0] er;
            logic        ec;
            string       t;
            er = q_data.pop_front();
            ec = q_carry.pop_front();
            t  = q_tag.pop_front();
            tests++;
            if (data_out !== er) begin
                fails++;
                $display("FAIL %s data: actual %h expected %h (kind %b amt %0d in %h)",
                         t, data_out, er, kind_sel, amount_in, data_in);
            end
            tests++;
            if (carry_out !== ec) begin
                fails++;
                $display("FAIL %s carry: actual %b expected %b (kind %b amt %0d in %h)",
                         t, carry_out, ec, kind_sel, amount_in, data_in);
            end
            tests++;
            if (extend_out !== ec) begin
                fails++;
                $display("FAIL R7 extend: actual %b expected %b", extend_out, ec);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9: all-zero inputs give all-zero outputs, no state
        drive(2'b00, 8'd0, 32'h0, 1'b0, "R9 reset-state");
        // R2: zero count keeps operand and carry in every kind
        for (int m = 0; m < 3; m++) begin
            drive(2'(m), 8'd0, 32'hA5C3_0F81, 1'b1, "R2 zero-count");
            drive(2'(m), 8'd0, 32'h8000_0001, 1'b0, "R2 zero-count");
        end
        // R1: only the count modulo 64 matters
        drive(2'b00, 8'h40, 32'h1234_5678, 1'b1, "R1 amount 64");
        drive(2'b01, 8'h41, 32'h8000_0003, 1'b0, "R1 amount 65");
        drive(2'b10, 8'hC5, 32'h9000_0010, 1'b0, "R1 amount 197");
        drive(2'b00, 8'hA0, 32'h0000_0001, 1'b0, "R1 amount 160");
        // R3: partial left shifts
        drive(2'b00, 8'd1,  32'h8000_0000, 1'b0, "R3 lsl 1");
        drive(2'b00, 8'd31, 32'h0000_0003, 1'b0, "R3 lsl 31");
        drive(2'b00, 8'd4,  32'hF123_4567, 1'b0, "R3 lsl 4");
        // R4: left by 32 and beyond
        drive(2'b00, 8'd32, 32'h0000_0001, 1'b0, "R4 lsl 32");
        drive(2'b00, 8'd32, 32'hFFFF_FFFE, 1'b1, "R4 lsl 32 low0");
        drive(2'b00, 8'd33, 32'hFFFF_FFFF, 1'b1, "R4 lsl 33");
        drive(2'b00, 8'd63, 32'hFFFF_FFFF, 1'b1, "R4 lsl 63");
        // R5: logical right
        drive(2'b01, 8'd1,  32'h0000_0001, 1'b0, "R5 lsr 1");
        drive(2'b01, 8'd31, 32'hC000_0000, 1'b0, "R5 lsr 31");
        drive(2'b01, 8'd32, 32'h8000_0000, 1'b0, "R5 lsr 32");
        drive(2'b01, 8'd40, 32'hFFFF_FFFF, 1'b1, "R5 lsr 40");
        // R6: arithmetic right
        drive(2'b10, 8'd1,  32'h8000_0001, 1'b0, "R6 asr 1");
        drive(2'b10, 8'd31, 32'hC000_0000, 1'b0, "R6 asr 31");
        drive(2'b10, 8'd32, 32'h8000_0000, 1'b0, "R6 asr 32 neg");
        drive(2'b10, 8'd32, 32'h7FFF_FFFF, 1'b1, "R6 asr 32 pos");
        drive(2'b10, 8'd63, 32'h8123_0000, 1'b0, "R6 asr 63");
        // R8: hold kind ignores count
        drive(2'b11, 8'd5,  32'hDEAD_BEEF, 1'b1, "R8 hold 5");
        drive(2'b11, 8'd32, 32'h0F0F_0F0F, 1'b0, "R8 hold 32");
        drive(2'b11, 8'd50, 32'h8000_0000, 1'b1, "R8 hold 50");
        // R9: new values every cycle, sweep of all kinds and counts
        for (int i = 0; i < 1500; i++) begin
            drive(2'($urandom_range(3, 0)), 8'($urandom_range(255, 0)),
                  $urandom, 1'($urandom_range(1, 0)), "R9 sweep R3 R5 R6");
        end
        while (q_data.size() > 0) @(posedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule